// File: doc/BRIEF.md
# CAN Bit Timing Generator

This block derives time quanta from the CAN core clock and lays out each nominal bit as a one-quantum synchronisation slot, a first timing segment (propagation plus phase 1) and a phase-2 segment. It emits a one-cycle sample strobe at the end of the first segment and a one-cycle bit-start strobe when a new bit begins. At the sample strobe it also latches the receive line into a held bit value.

Recessive-to-dominant (1 to 0) transitions on the receive line re-align the bit. The correction is limited by the jump width and is applied at most once per bit. A hard-sync request from the frame logic restarts the bit unconditionally.

The timing fields are raw register codes. The quantum length in core-clock cycles is `(brp_i + 1) + (brpe_i << 6)`. The first segment is `tseg1_i + 1` quanta, the second segment is `tseg2_i + 1` quanta and the jump width is `sjw_i + 1` quanta. The fields are meant to be changed only while `rst` is held, which plays the role of an initialisation mode.

Top module: `can_bit_timer`

## Requirements
- R1: One time quantum lasts `(brp_i + 1) + 64*brpe_i` clock cycles. `brp_i` is 6 bits (0 to 63) and `brpe_i` is 4 bits.
- R2: With no falling edge on `rx_i`, consecutive `bit_start_o` pulses are `(1 + (tseg1_i+1) + (tseg2_i+1))` quanta apart.
- R3: `sample_o` pulses `(1 + (tseg1_i+1))` quanta after `bit_start_o` when no correction applies. In the cycle of that pulse, `bit_o` takes the synchronised `rx_i` value, and `bit_o` keeps that value until the next pulse.
- R4: A falling edge inside the synchronisation quantum causes no correction.
- R5: A falling edge in the k-th quantum of the first segment (k = 1, 2, ...) lengthens that segment by min(k, sjw_i+1) quanta. This delays both the sample and the bit end.
- R6: A falling edge in the second segment, with r quanta of it still to run (counting the one that holds the edge), shortens that segment by min(r, sjw_i+1) quanta. When r ≤ sjw_i+1, the bit ends at the close of the quantum that holds the edge.
- R7: Only the first qualifying falling edge of a bit is corrected. Later edges in the same bit are ignored.
- R8: A rising edge on `rx_i` never changes bit timing.
- R9: A `hsync_i` pulse restarts the bit at once, with no jump-width limit. `bit_start_o` pulses in the next cycle. The sample follows `tseg1_i+1` quanta after that pulse, and the next bit start follows `(tseg1_i+1)+(tseg2_i+1)` quanta after it.
- R10: While `rst` is high, `sample_o` and `bit_start_o` are 0 and `bit_o` is 1.
- R11: `sample_o` and `bit_start_o` are never high in the same cycle, and `sample_o` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CAN core clock |
| rst | input | 1 | Synchronous active-high reset; timing fields may change only while it is high |
| rx_i | input | 1 | Receive line, 1 = recessive |
| hsync_i | input | 1 | Hard-sync request pulse |
| brp_i | input | 6 | Prescaler base code |
| brpe_i | input | 4 | Prescaler extension, weighted by 64 |
| tseg1_i | input | 4 | First segment length minus one, in quanta |
| tseg2_i | input | 3 | Second segment length minus one, in quanta |
| sjw_i | input | 2 | Jump width minus one, in quanta |
| bit_o | output | 1 | Bit value latched at the last sample point |
| sample_o | output | 1 | One-cycle sample-point strobe |
| bit_start_o | output | 1 | One-cycle bit-start strobe |

## Verification
The prescaler-range and segment-length assertions assume that the timing fields stay constant whenever reset is low. The bench therefore loads each timing set while reset is held and releases reset only afterwards. The bench changes `rx_i` a few cycles into a quantum, using prescalers of eight or more cycles, so that each edge clearly belongs to one quantum even after the receive flop. `hsync_i` is driven as an isolated single-cycle pulse.

// File: rtl/can_bt_pkg.sv
package can_bt_pkg;
  typedef enum logic [1:0] {
    SEG_SYNC = 2'd0,
    SEG_ONE  = 2'd1,
    SEG_TWO  = 2'd2
  } seg_e;
endpackage

// File: rtl/can_bt_quanta.sv
module can_bt_quanta #(
  parameter int BRP_W  = 6,
  parameter int BRPE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              restart_i,
  input  logic [BRP_W-1:0]  brp_i,
  input  logic [BRPE_W-1:0] brpe_i,
  output logic              tick_o
);
  localparam int CNT_W = BRP_W + BRPE_W;

  // divisor minus one: base plus extension weighted by 2**BRP_W
  logic [CNT_W-1:0] div_m1;
  logic [CNT_W-1:0] cnt_q;

  assign div_m1 = {brpe_i, brp_i};
  assign tick_o = (cnt_q == div_m1);

  always_ff @(posedge clk) begin
    if (rst || restart_i) cnt_q <= '0;
    else if (tick_o)      cnt_q <= '0;
    else                  cnt_q <= cnt_q + 1'b1;
  end

  // R1: the counter never runs past the programmed divisor
  p_cnt_in_range_r1: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= div_m1);
endmodule

// File: rtl/can_bt_rxedge.sv
module can_bt_rxedge #(
  parameter int DEPTH = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic rx_i,
  output logic rx_s_o,
  output logic fall_o
);
  logic [DEPTH-1:0] pipe_q;
  logic             prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pipe_q <= '1;
      prev_q <= 1'b1;
    end else begin
      pipe_q[0] <= rx_i;
      for (int i = 1; i < DEPTH; i++) pipe_q[i] <= pipe_q[i-1];
      prev_q <= pipe_q[DEPTH-1];
    end
  end

  assign rx_s_o = pipe_q[DEPTH-1];
  // R8: only recessive-to-dominant transitions are reported
  assign fall_o = prev_q & ~pipe_q[DEPTH-1];

  p_fall_is_drop_r8: assert property (@(posedge clk) disable iff (rst)
    fall_o |=> !prev_q);
endmodule

// File: rtl/can_bt_seq.sv
module can_bt_seq
  import can_bt_pkg::*;
#(
  parameter int T1_W  = 4,
  parameter int T2_W  = 3,
  parameter int SJW_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic             fall_i,
  input  logic             rx_s_i,
  input  logic             hsync_i,
  input  logic [T1_W-1:0]  tseg1_i,
  input  logic [T2_W-1:0]  tseg2_i,
  input  logic [SJW_W-1:0] sjw_i,
  output logic             sample_o,
  output logic             bit_o,
  output logic             bit_start_o
);
  localparam int MAX_A = (T1_W > T2_W) ? T1_W : T2_W;
  localparam int MAX_W = (MAX_A > SJW_W) ? MAX_A : SJW_W;
  localparam int LEN_W = MAX_W + 2;

  seg_e             seg_q;
  logic [LEN_W-1:0] cnt_q, len1_q, len2_q;
  logic             rs_done_q, pend_q;

  logic [LEN_W-1:0] t1, t2, sjw, cnt_inc, err2, corr1, corr2, len1_new, len2_new;
  logic             edge_now, do_rs;

  assign t1  = LEN_W'(tseg1_i) + LEN_W'(1);
  assign t2  = LEN_W'(tseg2_i) + LEN_W'(1);
  assign sjw = LEN_W'(sjw_i) + LEN_W'(1);

  assign cnt_inc  = cnt_q + LEN_W'(1);
  assign edge_now = pend_q | fall_i;
  assign do_rs    = edge_now & ~rs_done_q;

  // phase error: late edge counted from sync end, early edge to bit end
  assign err2  = len2_q - cnt_q;
  assign corr1 = (cnt_inc < sjw) ? cnt_inc : sjw;
  assign corr2 = (err2 < sjw) ? err2 : sjw;

  assign len1_new = (seg_q == SEG_ONE && do_rs) ? len1_q + corr1 : len1_q;
  assign len2_new = (seg_q == SEG_TWO && do_rs) ? len2_q - corr2 : len2_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      seg_q       <= SEG_SYNC;
      cnt_q       <= '0;
      len1_q      <= t1;
      len2_q      <= t2;
      rs_done_q   <= 1'b0;
      pend_q      <= 1'b0;
      sample_o    <= 1'b0;
      bit_start_o <= 1'b0;
      bit_o       <= 1'b1;
    end else if (hsync_i) begin
      seg_q       <= SEG_ONE;
      cnt_q       <= '0;
      len1_q      <= t1;
      len2_q      <= t2;
      rs_done_q   <= 1'b1;
      pend_q      <= 1'b0;
      sample_o    <= 1'b0;
      bit_start_o <= 1'b1;
    end else begin
      sample_o    <= 1'b0;
      bit_start_o <= 1'b0;
      pend_q      <= tick_i ? 1'b0 : (pend_q | fall_i);
      if (tick_i) begin
        case (seg_q)
          SEG_SYNC: begin
            seg_q  <= SEG_ONE;
            cnt_q  <= '0;
            len1_q <= t1;
            len2_q <= t2;
          end
          SEG_ONE: begin
            len1_q    <= len1_new;
            rs_done_q <= rs_done_q | do_rs;
            if (cnt_inc >= len1_new) begin
              seg_q    <= SEG_TWO;
              cnt_q    <= '0;
              sample_o <= 1'b1;
              bit_o    <= rx_s_i;
            end else begin
              cnt_q <= cnt_inc;
            end
          end
          SEG_TWO: begin
            len2_q <= len2_new;
            if (cnt_inc >= len2_new) begin
              seg_q       <= SEG_SYNC;
              cnt_q       <= '0;
              rs_done_q   <= 1'b0;
              bit_start_o <= 1'b1;
            end else begin
              cnt_q     <= cnt_inc;
              rs_done_q <= rs_done_q | do_rs;
            end
          end
          default: seg_q <= SEG_SYNC;
        endcase
      end
    end
  end

  // R5: first segment stays within nominal .. nominal + jump width
  p_len1_bounds_r5: assert property (@(posedge clk) disable iff (rst)
    (seg_q == SEG_ONE) |-> (len1_q >= t1 && len1_q <= t1 + sjw));
  // R7: once a bit has been corrected, segment lengths freeze
  p_one_resync_r7: assert property (@(posedge clk) disable iff (rst)
    (rs_done_q && !hsync_i) |=> ($stable(len1_q) && $stable(len2_q)));
  // R3: held bit moves only together with a sample strobe
  p_bit_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !sample_o |-> $stable(bit_o));
  // R11: strobes never coincide
  p_no_overlap_r11: assert property (@(posedge clk) disable iff (rst)
    !(sample_o && bit_start_o));
  // R11: sample strobe lasts one cycle
  p_sample_single_r11: assert property (@(posedge clk) disable iff (rst)
    sample_o |=> !sample_o);
endmodule

// File: rtl/can_bit_timer.sv
module can_bit_timer #(
  parameter int BRP_W   = 6,
  parameter int BRPE_W  = 4,
  parameter int T1_W    = 4,
  parameter int T2_W    = 3,
  parameter int SJW_W   = 2,
  parameter int RX_SYNC = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_i,
  input  logic              hsync_i,
  input  logic [BRP_W-1:0]  brp_i,
  input  logic [BRPE_W-1:0] brpe_i,
  input  logic [T1_W-1:0]   tseg1_i,
  input  logic [T2_W-1:0]   tseg2_i,
  input  logic [SJW_W-1:0]  sjw_i,
  output logic              bit_o,
  output logic              sample_o,
  output logic              bit_start_o
);
  logic tick, rx_s, fall;

  can_bt_quanta #(.BRP_W(BRP_W), .BRPE_W(BRPE_W)) u_quanta (
    .clk(clk), .rst(rst), .restart_i(hsync_i),
    .brp_i(brp_i), .brpe_i(brpe_i), .tick_o(tick)
  );

  can_bt_rxedge #(.DEPTH(RX_SYNC)) u_rxedge (
    .clk(clk), .rst(rst), .rx_i(rx_i), .rx_s_o(rx_s), .fall_o(fall)
  );

  can_bt_seq #(.T1_W(T1_W), .T2_W(T2_W), .SJW_W(SJW_W)) u_seq (
    .clk(clk), .rst(rst), .tick_i(tick), .fall_i(fall), .rx_s_i(rx_s),
    .hsync_i(hsync_i), .tseg1_i(tseg1_i), .tseg2_i(tseg2_i), .sjw_i(sjw_i),
    .sample_o(sample_o), .bit_o(bit_o), .bit_start_o(bit_start_o)
  );
endmodule

// File: tb/can_bit_timer_bench.sv
module can_bit_timer_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rx_i = 1'b1;
  logic       hsync_i = 1'b0;
  logic [5:0] brp_i = '0;
  logic [3:0] brpe_i = '0;
  logic [3:0] tseg1_i = '0;
  logic [2:0] tseg2_i = '0;
  logic [1:0] sjw_i = '0;
  logic       bit_o, sample_o, bit_start_o;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  can_bit_timer u_can_bit_timer (
    .clk(clk), .rst(rst), .rx_i(rx_i), .hsync_i(hsync_i),
    .brp_i(brp_i), .brpe_i(brpe_i), .tseg1_i(tseg1_i), .tseg2_i(tseg2_i),
    .sjw_i(sjw_i), .bit_o(bit_o), .sample_o(sample_o), .bit_start_o(bit_start_o)
  );

  // timing vectors and expected cycle offsets from a bit start
  localparam int NV = 5;
  localparam int V_BRP  [NV] = '{0, 2, 10, 63, 0};
  localparam int V_BRPE [NV] = '{0, 0, 1, 0, 2};
  localparam int V_TS1  [NV] = '{3, 5, 1, 0, 15};
  localparam int V_TS2  [NV] = '{2, 1, 0, 0, 7};
  localparam int V_SJW  [NV] = '{0, 1, 3, 0, 2};
  localparam int V_SAMP [NV] = '{5, 21, 225, 128, 2193};
  localparam int V_BIT  [NV] = '{8, 27, 300, 192, 3225};

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic apply_cfg(input int b, input int be, input int t1, input int t2,
                           input int s, input bit chk_rst);
    @(negedge clk);
    rst = 1'b1; rx_i = 1'b1; hsync_i = 1'b0;
    brp_i = 6'(b); brpe_i = 4'(be); tseg1_i = 4'(t1); tseg2_i = 3'(t2); sjw_i = 2'(s);
    repeat (3) @(negedge clk);
    if (chk_rst) begin
      check("R10 sample_o in reset", int'(sample_o), 0);
      check("R10 bit_start_o in reset", int'(bit_start_o), 0);
      check("R10 bit_o in reset", int'(bit_o), 1);
    end
    rst = 1'b0;
  endtask

  task automatic wait_start();
    for (int c = 0; c < 8000; c++) begin
      @(negedge clk);
      if (bit_start_o) return;
    end
  endtask

  // runs one bit from an observed bit start; rx changes at given offsets
  task automatic run_bit(input int fall_at, input int rise_at, input int fall2_at,
                         output int s_off, output int e_off, output int bv);
    s_off = -1; e_off = -1; bv = -1;
    for (int c = 1; c < 8000; c++) begin
      @(negedge clk);
      if (sample_o) begin s_off = c; bv = int'(bit_o); end
      if (bit_start_o) begin e_off = c; return; end
      if (c == fall_at || c == fall2_at) rx_i = 1'b0;
      if (c == rise_at) rx_i = 1'b1;
    end
  endtask

  task automatic directed(input string tag, input int f1, input int r1, input int f2,
                          input int es, input int ee);
    int s, e, bv;
    apply_cfg(7, 0, 3, 2, 1, 1'b0);
    wait_start();
    run_bit(f1, r1, f2, s, e, bv);
    check({tag, " sample offset"}, s, es);
    check({tag, " bit end offset"}, e, ee);
  endtask

  initial begin
    int s, e, bv;
    // vector table: R1 quantum, R2 period, R3 sample position
    for (int i = 0; i < NV; i++) begin
      apply_cfg(V_BRP[i], V_BRPE[i], V_TS1[i], V_TS2[i], V_SJW[i], i == 0);
      wait_start();
      run_bit(-1, -1, -1, s, e, bv);
      check("R3 sample offset (R1 quantum)", s, V_SAMP[i]);
      check("R2 bit period (R1 quantum)", e, V_BIT[i]);
    end

    // quantum = 8 cycles, seg1 = 4, seg2 = 3, jump width = 2
    // R4 edge in sync quantum, R8 rising edge in seg2, R3 bit value
    apply_cfg(7, 0, 3, 2, 1, 1'b0);
    wait_start();
    run_bit(3, 51, -1, s, e, bv);
    check("R4 sample offset, sync edge", s, 40);
    check("R3 sampled value dominant", bv, 0);
    check("R8 bit end unchanged by rise", e, 64);
    run_bit(-1, -1, -1, s, e, bv);
    check("R8 sample offset next bit", s, 40);
    check("R3 sampled value recessive", bv, 1);
    check("R4 bit end next bit", e, 64);

    directed("R5 lengthen by 1", 11, -1, -1, 48, 72);
    directed("R5 lengthen clamped to SJW", 27, -1, -1, 56, 80);
    directed("R6 shorten to edge quantum", 51, -1, -1, 40, 56);
    directed("R6 shorten clamped to SJW", 43, -1, -1, 40, 48);
    directed("R7 second edge ignored", 11, 19, 27, 48, 72);

    // R9 hard sync in the middle of the first segment
    apply_cfg(7, 0, 3, 2, 1, 1'b0);
    wait_start();
    repeat (20) @(negedge clk);
    hsync_i = 1'b1;
    @(negedge clk);
    hsync_i = 1'b0;
    check("R9 bit start after hard sync", int'(bit_start_o), 1);
    run_bit(-1, -1, -1, s, e, bv);
    check("R9 sample after hard sync", s, 32);
    check("R9 bit end after hard sync", e, 56);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule